// File: doc/BRIEF.md
# Debug Trace Ring Buffer

This block keeps a rolling history of a processor core's internal status. On every clock where logging is allowed it stores one wide status word into a circular array, so the array always holds the most recent entries. A one-bit wrap flag flips each time the write position passes the last slot. The flag and the write position together let software tell how far the history reaches back and where the newest entry sits.

The array can be read from two sides through a single shared read port. The core side presents a byte-free word address and receives one 64-bit slice of an entry. The debug side loads an address register and reads a 64-bit data register. Each completed access to that data register moves the debug address to the next slice, so a debugger can drain the buffer with repeated data reads. Setting the most significant bit of either read address freezes logging, so the history cannot change while it is being read out.

Top module: `trace_ring_buffer`

## Requirements
- R1: While `rst` is high at a clock edge, the write position becomes 0 and the wrap flag becomes 0. `dbg_addr_o`, `dbg_data_o` and `core_rdata_o` all read 0, and `wr_pos_o` reads exactly 2^IDX_W, where IDX_W = log2(DEPTH).
- R2: At every clock edge where logging is allowed, `log_word_i` is stored in the entry at the write position. The write position then advances by one, modulo DEPTH.
- R3: `wrap_o` inverts at each edge where a write happens while the write position equals DEPTH-1. At every other edge it holds its value.
- R4: Logging is blocked on any edge where bit 31 of `core_raddr_i` is 1, or where bit 31 of the stored debug address (`dbg_addr_o`) is 1. While blocked, the write position, `wr_pos_o` and `wrap_o` hold their values.
- R5: In `wr_pos_o`, bits [IDX_W-1:0] hold the write position, bit IDX_W is 1 and every higher bit is 0.
- R6: An address selects entry bits [IDX_W+1:2] and lane bits [1:0]. Lane n is entry bits 64n+63 down to 64n. When `core_raddr_i` is held steady, `core_rdata_o` shows the selected lane after the third clock edge following the edge at which the address was first sampled.
- R7: When `dbg_addr_we_i` is high at an edge, `dbg_addr_wdata_i` is loaded into `dbg_addr_o` and a debug read starts. The addressed lane appears on `dbg_data_o` after the third edge following the load edge. `dbg_data_o` changes at no other time except at the end of such a read.
- R8: When `dbg_data_req_i` is sampled low at an edge after having been sampled high at the previous edge, and no address write happens at that edge, two things occur. First, the low IDX_W+2 bits of the debug address increment by one, wrapping within that field, while the higher bits are kept. Second, a debug read of the new address starts, and its result appears on `dbg_data_o` after the third edge following the increment edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| log_word_i | input | ENTRY_W | Status word to record |
| core_raddr_i | input | 32 | Core-side read address; bit 31 freezes logging |
| core_rdata_o | output | LANE_W | Core-side read data (one lane) |
| wr_pos_o | output | 32 | Current write position with marker bit |
| wrap_o | output | 1 | Flag that flips on every pass over the last slot |
| dbg_addr_we_i | input | 1 | Load the debug address register |
| dbg_addr_wdata_i | input | 32 | Value for the debug address register |
| dbg_data_req_i | input | 1 | Held high for an access to the debug data register |
| dbg_addr_o | output | 32 | Current debug address |
| dbg_data_o | output | LANE_W | Debug data register |

## Verification
The bench builds the block with DEPTH = 16, a 256-bit entry and a 64-bit lane. With these values the index field is four bits and the auto-increment field is six bits. A run of 21 logged words therefore passes the last slot once and makes the wrap flag visible. The small increment field also lets a single data-register access carry the debug address from 0x...3F across to 0x...00 with the upper bits untouched. Both freeze sources are exercised separately, and logging is resumed between them to confirm that the write position moves again.

// File: rtl/trb_pkg.sv
package trb_pkg;
   localparam int unsigned ADDR_W     = 32;
   localparam int unsigned FREEZE_BIT = ADDR_W - 1;

   typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/trb_write_ctrl.sv
module trb_write_ctrl #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    freeze_i,
   output logic                    wr_en_o,
   output logic [IDX_W-1:0]        wptr_o,
   output logic                    wrap_o,
   output trb_pkg::addr_t          wr_pos_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] wptr_q;
   logic             tog_q;

   assign wr_en_o = ~freeze_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q <= '0;
         tog_q  <= 1'b0;
      end else if (wr_en_o) begin
         wptr_q <= wptr_q + 1'b1;
         if (wptr_q == LAST) begin
            tog_q <= ~tog_q;
         end
      end
   end

   always_comb begin
      wr_pos_o              = '0;
      wr_pos_o[IDX_W-1:0]   = wptr_q;
      wr_pos_o[IDX_W]       = 1'b1;
   end

   assign wptr_o = wptr_q;
   assign wrap_o = tog_q;

   // R2: each permitted write moves the pointer one slot on
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |=> wptr_q == $past(wptr_q) + 1'b1);

   // R4: a frozen cycle leaves pointer and flag alone
   a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en_o |=> ($stable(wptr_q) && $stable(tog_q)));

   // R3: writing the last slot flips the flag
   a_r3_wrap_flip: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && wptr_q == LAST) |=> tog_q != $past(tog_q));

   // R3: any other cycle keeps the flag
   a_r3_wrap_keep: assert property (@(posedge clk) disable iff (rst)
      !(wr_en_o && wptr_q == LAST) |=> $stable(tog_q));
endmodule

// File: rtl/trb_ram.sv
module trb_ram #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned WIDTH = 256,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  waddr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   input  logic [IDX_W-1:0]  raddr_i,
   output logic [WIDTH-1:0]  rdata_o
);
   logic [WIDTH-1:0] mem [DEPTH];

   // Read-before-write: a same-slot read sees the previous contents.
   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
      rdata_o <= mem[raddr_i];
   end
endmodule

// File: rtl/trb_dbg_port.sv
module trb_dbg_port #(
   parameter int unsigned IDX_W = 9,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned INC_W = IDX_W + SEL_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                addr_we_i,
   input  trb_pkg::addr_t      addr_wdata_i,
   input  logic                data_req_i,
   input  logic [INC_W-1:0]    core_low_i,
   output trb_pkg::addr_t      addr_o,
   output logic [IDX_W-1:0]    rd_idx_o,
   output logic                done_o
);
   trb_pkg::addr_t   addr_q;
   logic             req_q;
   logic             rd_req_q;
   logic             reading_q;
   logic             done_q;
   logic [IDX_W-1:0] rd_idx_q;
   logic             req_fall;

   assign req_fall = req_q & ~data_req_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q    <= '0;
         req_q     <= 1'b0;
         rd_req_q  <= 1'b0;
         reading_q <= 1'b0;
         done_q    <= 1'b0;
         rd_idx_q  <= '0;
      end else begin
         req_q    <= data_req_i;
         rd_req_q <= 1'b0;
         if (addr_we_i) begin
            addr_q   <= addr_wdata_i;
            rd_req_q <= 1'b1;
         end else if (req_fall) begin
            addr_q[INC_W-1:0] <= addr_q[INC_W-1:0] + 1'b1;
            rd_req_q          <= 1'b1;
         end
         reading_q <= rd_req_q;
         done_q    <= reading_q;
         // The shared read port serves the debugger only in its request cycle.
         rd_idx_q  <= rd_req_q ? addr_q[INC_W-1:SEL_W] : core_low_i[INC_W-1:SEL_W];
      end
   end

   assign addr_o   = addr_q;
   assign rd_idx_o = rd_idx_q;
   assign done_o   = done_q;

   // R7: an address write loads the register and opens a read
   a_r7_addr_load: assert property (@(posedge clk) disable iff (rst)
      addr_we_i |=> (rd_req_q && addr_q == $past(addr_wdata_i)));

   // R7: request -> reading -> done, one stage per cycle
   a_r7_stage_one: assert property (@(posedge clk) disable iff (rst)
      rd_req_q |=> reading_q);
   a_r7_stage_two: assert property (@(posedge clk) disable iff (rst)
      reading_q |=> done_q);

   // R8: the end of a data access bumps only the low field
   a_r8_low_bump: assert property (@(posedge clk) disable iff (rst)
      (req_fall && !addr_we_i) |=>
         (addr_q[INC_W-1:0] == $past(addr_q[INC_W-1:0]) + 1'b1
          && $stable(addr_q[trb_pkg::ADDR_W-1:INC_W]) && rd_req_q));
endmodule

// File: rtl/trb_lane_out.sv
module trb_lane_out #(
   parameter int unsigned ENTRY_W = 256,
   parameter int unsigned LANE_W  = 64,
   parameter int unsigned LANES   = ENTRY_W / LANE_W,
   parameter int unsigned SEL_W   = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                done_i,
   input  logic [ENTRY_W-1:0]  entry_i,
   input  logic [SEL_W-1:0]    core_sel_i,
   input  logic [SEL_W-1:0]    dbg_sel_i,
   output logic [LANE_W-1:0]   core_rdata_o,
   output logic [LANE_W-1:0]   dbg_data_o
);
   logic [LANE_W-1:0] lanes [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = entry_i[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         core_rdata_o <= '0;
         dbg_data_o   <= '0;
      end else if (done_i) begin
         dbg_data_o   <= lanes[dbg_sel_i];
      end else begin
         core_rdata_o <= lanes[core_sel_i];
      end
   end

   // R7: the debug data register only changes at the end of a debug read
   a_r7_dbg_hold: assert property (@(posedge clk) disable iff (rst)
      !done_i |=> $stable(dbg_data_o));
endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer #(
   parameter int unsigned DEPTH   = 512,
   parameter int unsigned ENTRY_W = 256,
   parameter int unsigned LANE_W  = 64
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ENTRY_W-1:0]  log_word_i,
   input  logic [31:0]         core_raddr_i,
   output logic [LANE_W-1:0]   core_rdata_o,
   output logic [31:0]         wr_pos_o,
   output logic                wrap_o,
   input  logic                dbg_addr_we_i,
   input  logic [31:0]         dbg_addr_wdata_i,
   input  logic                dbg_data_req_i,
   output logic [31:0]         dbg_addr_o,
   output logic [LANE_W-1:0]   dbg_data_o
);
   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned LANES = ENTRY_W / LANE_W;
   localparam int unsigned SEL_W = $clog2(LANES);
   localparam int unsigned INC_W = IDX_W + SEL_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANES < 2 || (ENTRY_W % LANE_W) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("ENTRY_W must hold a power-of-two count (>=2) of LANE_W lanes");
   end
   if (INC_W > 30) begin : g_bad_span
      $error("address field too wide for the freeze bit");
   end

   logic                 freeze;
   logic                 wr_en;
   logic [IDX_W-1:0]     wptr;
   logic [IDX_W-1:0]     rd_idx;
   logic                 done;
   logic [ENTRY_W-1:0]   ram_q;
   trb_pkg::addr_t       dbg_addr;
   logic                 unused_hi;

   assign unused_hi = ^core_raddr_i[30:INC_W];
   assign freeze    = core_raddr_i[trb_pkg::FREEZE_BIT] | dbg_addr[trb_pkg::FREEZE_BIT];

   trb_write_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wctl (
      .clk      (clk),
      .rst      (rst),
      .freeze_i (freeze),
      .wr_en_o  (wr_en),
      .wptr_o   (wptr),
      .wrap_o   (wrap_o),
      .wr_pos_o (wr_pos_o)
   );

   trb_dbg_port #(.IDX_W(IDX_W), .SEL_W(SEL_W), .INC_W(INC_W)) u_dbg (
      .clk          (clk),
      .rst          (rst),
      .addr_we_i    (dbg_addr_we_i),
      .addr_wdata_i (dbg_addr_wdata_i),
      .data_req_i   (dbg_data_req_i),
      .core_low_i   (core_raddr_i[INC_W-1:0]),
      .addr_o       (dbg_addr),
      .rd_idx_o     (rd_idx),
      .done_o       (done)
   );

   trb_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .IDX_W(IDX_W)) u_ram (
      .clk     (clk),
      .we_i    (wr_en),
      .waddr_i (wptr),
      .wdata_i (log_word_i),
      .raddr_i (rd_idx),
      .rdata_o (ram_q)
   );

   trb_lane_out #(.ENTRY_W(ENTRY_W), .LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) u_out (
      .clk          (clk),
      .rst          (rst),
      .done_i       (done),
      .entry_i      (ram_q),
      .core_sel_i   (core_raddr_i[SEL_W-1:0]),
      .dbg_sel_i    (dbg_addr[SEL_W-1:0]),
      .core_rdata_o (core_rdata_o),
      .dbg_data_o   (dbg_data_o)
   );

   assign dbg_addr_o = dbg_addr;

   // R4: either freeze source keeps the reported position still
   a_r4_pos_frozen: assert property (@(posedge clk) disable iff (rst)
      freeze |=> ($stable(wr_pos_o) && $stable(wrap_o)));

   // R5: marker bit present and nothing above it
   a_r5_pos_marker: assert property (@(posedge clk) disable iff (rst)
      (wr_pos_o >> IDX_W) == 32'd1);
endmodule

// File: tb/sim_trace_ring_buffer.sv
module sim_trace_ring_buffer;
   localparam int DEPTH = 16;
   localparam int EW    = 256;
   localparam int LW    = 64;

   logic          clk = 1'b0;
   logic          rst;
   logic [EW-1:0] log_word;
   logic [31:0]   core_raddr;
   logic [LW-1:0] core_rdata;
   logic [31:0]   wr_pos;
   logic          wrap;
   logic          dbg_we;
   logic [31:0]   dbg_wdata;
   logic          dbg_req;
   logic [31:0]   dbg_addr;
   logic [LW-1:0] dbg_data;

   always #5 clk = ~clk;

   trace_ring_buffer #(.DEPTH(DEPTH), .ENTRY_W(EW), .LANE_W(LW)) u0 (
      .clk              (clk),
      .rst              (rst),
      .log_word_i       (log_word),
      .core_raddr_i     (core_raddr),
      .core_rdata_o     (core_rdata),
      .wr_pos_o         (wr_pos),
      .wrap_o           (wrap),
      .dbg_addr_we_i    (dbg_we),
      .dbg_addr_wdata_i (dbg_wdata),
      .dbg_data_req_i   (dbg_req),
      .dbg_addr_o       (dbg_addr),
      .dbg_data_o       (dbg_data)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int seq    = 0;

   function automatic logic [EW-1:0] pat(int s);
      logic [EW-1:0] w;
      for (int l = 0; l < 4; l++) w[l*64 +: 64] = {32'(s), 32'hC0DE_0000 | 32'(l)};
      return w;
   endfunction

   // stimulus word changes once per cycle, away from the active edge
   initial log_word = pat(0);
   always @(negedge clk) begin
      seq      <= seq + 1;
      log_word <= pat(seq + 1);
   end

   // reference model of the array contents, built from R2..R4
   logic [EW-1:0] model [DEPTH];
   int   mwp  = 0;
   logic mtog = 1'b0;
   always @(posedge clk) begin
      if (rst) begin
         mwp  = 0;
         mtog = 1'b0;
      end else if (!core_raddr[31] && !dbg_addr[31]) begin
         model[mwp] = log_word;
         if (mwp == DEPTH - 1) mtog = ~mtog;
         mwp = (mwp + 1) % DEPTH;
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard: driver pushes, monitor pops on each sample event
   typedef struct {
      string       req;
      bit          from_dbg;
      logic [63:0] exp;
   } item_t;
   item_t sb[$];
   event  sample_ev;

   always @(sample_ev) begin
      item_t it;
      it = sb.pop_front();
      chk(it.req, it.from_dbg ? dbg_data : core_rdata, it.exp);
   end

   task automatic expect_data(string req, bit from_dbg, int idx, int lane);
      item_t it;
      it.req      = req;
      it.from_dbg = from_dbg;
      it.exp      = model[idx][lane*64 +: 64];
      sb.push_back(it);
      -> sample_ev;
      #1;
   endtask

   task automatic core_read(string req, int idx, int lane);
      @(negedge clk);
      core_raddr = 32'h8000_0000 | 32'(idx << 2) | 32'(lane);
      repeat (3) @(posedge clk);
      @(negedge clk);
      expect_data(req, 1'b0, idx, lane);
   endtask

   task automatic dbg_load(logic [31:0] a);
      @(negedge clk);
      dbg_we    = 1'b1;
      dbg_wdata = a;
      @(posedge clk);
      @(negedge clk);
      dbg_we    = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic dbg_access;
      @(negedge clk);
      dbg_req = 1'b1;
      @(negedge clk);
      dbg_req = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst        = 1'b1;
      core_raddr = 32'h0;
      dbg_we     = 1'b0;
      dbg_wdata  = 32'h0;
      dbg_req    = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset values
      chk("R1 wr_pos", 64'(wr_pos), 64'h10);
      chk("R1 wrap", 64'(wrap), 64'h0);
      chk("R1 dbg_addr", 64'(dbg_addr), 64'h0);
      chk("R1 dbg_data", dbg_data, 64'h0);
      chk("R1 core_rdata", core_rdata, 64'h0);
      rst = 1'b0;

      // log 21 words, then freeze via the core address
      repeat (21) @(negedge clk);
      core_raddr = 32'h8000_0000;
      @(negedge clk);
      chk("R5 R2 wr_pos after 21 writes", 64'(wr_pos), 64'h15);
      chk("R3 wrap after one pass", 64'(wrap), 64'h1);
      repeat (5) @(negedge clk);
      chk("R4 core freeze holds wr_pos", 64'(wr_pos), 64'h15);

      // R6 core-side reads with lane selection
      core_read("R6 idx4 lane0", 4, 0);
      core_read("R6 idx4 lane3", 4, 3);
      core_read("R6 idx0 lane1", 0, 1);
      core_read("R6 idx15 lane2", 15, 2);

      // R7 debug address load and read
      dbg_load(32'h8000_0000 | 32'(7 << 2) | 32'd2);
      chk("R7 dbg_addr loaded", 64'(dbg_addr), 64'h8000_001E);
      expect_data("R7 dbg idx7 lane2", 1'b1, 7, 2);

      // R8 auto-advance after each data access
      dbg_access();
      chk("R8 addr step", 64'(dbg_addr), 64'h8000_001F);
      expect_data("R8 dbg idx7 lane3", 1'b1, 7, 3);
      dbg_access();
      chk("R8 addr into next entry", 64'(dbg_addr), 64'h8000_0020);
      expect_data("R8 dbg idx8 lane0", 1'b1, 8, 0);

      // R8 wrap of the low field keeps upper bits
      dbg_load(32'h8000_013F);
      expect_data("R7 dbg idx15 lane3", 1'b1, 15, 3);
      dbg_access();
      chk("R8 low field wraps", 64'(dbg_addr), 64'h8000_0100);
      expect_data("R8 dbg idx0 lane0", 1'b1, 0, 0);

      // R4 freeze from the debug address alone
      @(negedge clk);
      core_raddr = 32'h0000_0000;
      repeat (4) @(negedge clk);
      chk("R4 debug freeze holds wr_pos", 64'(wr_pos), 64'h15);

      // clear debug freeze: three writes land before freezing again
      dbg_load(32'h0000_0000);
      core_raddr = 32'h8000_0000;
      @(negedge clk);
      chk("R2 logging resumes", 64'(wr_pos), 64'h18);
      chk("R3 wrap held mid pass", 64'(wrap), 64'h1);
      core_read("R2 newest entry idx7", 7, 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule